// File: doc/BRIEF.md
# Interrupt translator enable and idle controller

This block holds the single control word of an interrupt translation unit. Software uses it to switch the unit on and off. While the unit is off, incoming translation writes are dropped and the command queue stops. The word also holds a per-unit number, one implementation-defined control bit and the enable for an interrupt that reports unmapped messages. The translation datapath, the command queue and the memory tables sit outside this block. Their state reaches it as two counters: transactions in progress, and forwarded operations still waiting for a downstream acknowledgement. A third input is the flag that an unmapped message has been seen.

The top bit of the word is a read-only idle flag. Power management polls it before it removes power from the unit. The flag rises only when the unit is disabled and both counters have drained to zero. After software sets the enable, the flag keeps reading 1 until the new enable takes effect, and then it drops. Two kinds of write are illegal: enabling a unit that is not idle, and changing the unit number while the unit is busy or enabled. The offending field of such a write is left unchanged and a sticky error output is raised.

Top module: `xlat_ctl_top`

## Requirements
- R1: After reset, the word reads 0x8000_0000 (idle 1, every other field 0), and the translate enable, queue enable, interrupt and error outputs are all 0.
- R2: An accepted write of the enable field (bit 0) reads back at once. The translate and queue enable outputs follow it one clock edge after the write edge.
- R3: After the enable is set, the idle flag (bit 31) keeps reading 1 until the enable outputs rise. It reads 0 from that same edge onward.
- R4: While the unit is disabled, the idle flag reads 0 as long as either counter is nonzero. It rises on the first clock edge at which both counters are zero.
- R5: The idle flag is never 1 while the enable outputs are 1.
- R6: A write that sets bit 0 while the enable is 0 and the idle flag is 0 leaves the enable at 0 and raises the error output.
- R7: A write that changes the unit number (bits 7:4) while the idle flag is 0, or while the enable is set or in effect, leaves the number unchanged and raises the error output. The other fields of that write are still applied.
- R8: The interrupt output is 1 exactly when the interrupt enable (bit 8) and the unmapped-message input are both 1.
- R9: Bit 1 is a plain read/write bit. Bits 30:9 and 3:2 read as 0 and ignore written ones.
- R10: Only word address 0 is decoded. Writes to any other address change nothing, and reads from them return 0.
- R11: The error output stays 1 once raised, through later legal writes, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address, same cycle |
| outst_cnt_i | input | CNT_W | Transactions in progress |
| ack_pend_i | input | CNT_W | Forwarded operations awaiting acknowledgement |
| unmapped_i | input | 1 | Unmapped-message status flag |
| xlat_en_o | output | 1 | Translation writes accepted |
| cmdq_en_o | output | 1 | Command queue processing allowed |
| unmapped_irq_o | output | 1 | Unmapped-message interrupt |
| err_o | output | 1 | Sticky illegal-write flag |

## Verification
The bench builds the block with ADDR_W = 6 and CNT_W = 4. The small address width keeps the test of a non-zero address short. The narrow counters are wide enough to hold outstanding work across several cycles while the bench drains the two counters in turn. These values let the bench reach each interleaving it needs: a counter drains while the other is still pending, the enable is set from a busy state, and the unit number changes while the unit is busy or while it is enabled. Each of these is checked against the exact edge at which the idle flag and the enable outputs should move.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;
  localparam int REG_W     = 32;
  localparam int EN_BIT    = 0;
  localparam int AUX_BIT   = 1;
  localparam int UNIT_LSB  = 4;
  localparam int UNIT_W    = 4;
  localparam int IRQEN_BIT = 8;
  localparam int IDLE_BIT  = 31;

  typedef struct packed {
    logic              irq_en;
    logic [UNIT_W-1:0] unit;
    logic              aux;
    logic              en;
  } ctl_t;
endpackage

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
  import xlat_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             idle_i,
  input  logic             en_eff_i,
  output ctl_t             ctl_o,
  output logic             err_o
);
  ctl_t ctl_q;
  logic err_q;
  logic [UNIT_W-1:0] unit_new;
  logic en_bad, unit_bad;

  assign unit_new = wdata_i[UNIT_LSB +: UNIT_W];
  // enabling from a busy state
  assign en_bad   = wr_i && wdata_i[EN_BIT] && !ctl_q.en && !idle_i;
  // renumbering while busy or enabled
  assign unit_bad = wr_i && (unit_new != ctl_q.unit) && (!idle_i || ctl_q.en || en_eff_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_i) begin
        ctl_q.aux    <= wdata_i[AUX_BIT];
        ctl_q.irq_en <= wdata_i[IRQEN_BIT];
        if (!en_bad)   ctl_q.en   <= wdata_i[EN_BIT];
        if (!unit_bad) ctl_q.unit <= unit_new;
      end
      if (en_bad || unit_bad) err_q <= 1'b1;
    end
  end

  assign ctl_o = ctl_q;
  assign err_o = err_q;

  // R6
  en_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_bad |=> (!ctl_q.en && err_q));
  // R7
  unit_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_bad |=> ($stable(ctl_q.unit) && err_q));
  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/xlat_ctl_idle.sv
module xlat_ctl_idle #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_req_i,
  input  logic [CNT_W-1:0] outst_cnt_i,
  input  logic [CNT_W-1:0] ack_pend_i,
  output logic             en_eff_o,
  output logic             idle_o
);
  logic en_eff_q, idle_q, drained;

  assign drained = (outst_cnt_i == '0) && (ack_pend_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_eff_q <= 1'b0;
      idle_q   <= 1'b1;
    end else begin
      en_eff_q <= en_req_i;
      // a pending enable already blocks idle, so it drops as the enable lands
      idle_q   <= !en_req_i && !en_eff_q && drained;
    end
  end

  assign en_eff_o = en_eff_q;
  assign idle_o   = idle_q;

  // R2
  en_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_eff_q == $past(en_req_i));
  // R3
  idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_eff_q) |-> !idle_q);
  // R4
  idle_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_q) |-> $past(drained));
  // R5
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q |-> !en_eff_q);
endmodule

// File: rtl/xlat_ctl_top.sv
module xlat_ctl_top
  import xlat_ctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [CNT_W-1:0]  outst_cnt_i,
  input  logic [CNT_W-1:0]  ack_pend_i,
  input  logic              unmapped_i,
  output logic              xlat_en_o,
  output logic              cmdq_en_o,
  output logic              unmapped_irq_o,
  output logic              err_o
);
  logic hit, wr, idle, en_eff;
  ctl_t ctl;
  logic unused_wbits;

  assign hit = (reg_addr_i == '0);
  assign wr  = reg_req_i && reg_we_i && hit;
  assign unused_wbits = ^{reg_wdata_i[REG_W-1:IRQEN_BIT+1], reg_wdata_i[UNIT_LSB-1:AUX_BIT+1]};

  xlat_ctl_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .wdata_i  (reg_wdata_i),
    .idle_i   (idle),
    .en_eff_i (en_eff),
    .ctl_o    (ctl),
    .err_o    (err_o)
  );

  xlat_ctl_idle #(.CNT_W(CNT_W)) u_idle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_req_i    (ctl.en),
    .outst_cnt_i (outst_cnt_i),
    .ack_pend_i  (ack_pend_i),
    .en_eff_o    (en_eff),
    .idle_o      (idle)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (hit) begin
      reg_rdata_o[EN_BIT]                = ctl.en;
      reg_rdata_o[AUX_BIT]               = ctl.aux;
      reg_rdata_o[UNIT_LSB +: UNIT_W]    = ctl.unit;
      reg_rdata_o[IRQEN_BIT]             = ctl.irq_en;
      reg_rdata_o[IDLE_BIT]              = idle;
    end
  end

  assign xlat_en_o      = en_eff;
  assign cmdq_en_o      = en_eff;
  assign unmapped_irq_o = ctl.irq_en && unmapped_i;

  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_irq_o |-> (unmapped_i && reg_rdata_o[IRQEN_BIT] || !hit));
  // R10
  addr_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && !hit) |=> $stable(ctl));
  // R10
  addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (reg_rdata_o == '0));
endmodule

// File: tb/xlat_ctl_top_test.sv
module xlat_ctl_top_test;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, unm = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [CNT_W-1:0] outst = '0, ackp = '0;
  logic xlat_en, cmdq_en, irq, err;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  xlat_ctl_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .outst_cnt_i(outst), .ack_pend_i(ackp), .unmapped_i(unm),
    .xlat_en_o(xlat_en), .cmdq_en_o(cmdq_en), .unmapped_irq_o(irq), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as reads appear
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (req && !we) begin
        item_t it;
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: unexpected read, actual %h expected none", rdata);
        end else begin
          it = sb_q.pop_front();
          chk(it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_at(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; addr = '0;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_at('0, d);
  endtask

  task automatic rd_at(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [31:0] e, input string tag);
    rd_at('0, e, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d reads not seen, expected 0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    rd(32'h8000_0000, "R1 reset word");
    chk("R1 xlat_en", {31'b0, xlat_en}, 32'd0);
    chk("R1 cmdq_en", {31'b0, cmdq_en}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 err", {31'b0, err}, 32'd0);

    // R2 / R3 enable timing
    wr(32'h1);
    chk("R2 enable not yet", {31'b0, xlat_en}, 32'd0);
    rd(32'h8000_0001, "R3 idle holds before enable lands");
    chk("R2 xlat_en on", {31'b0, xlat_en}, 32'd1);
    chk("R2 cmdq_en on", {31'b0, cmdq_en}, 32'd1);
    rd(32'h0000_0001, "R3 idle drops");

    // R4 drain
    outst = 4'd3;
    step();
    wr(32'h0);
    chk("R2 disable not yet", {31'b0, xlat_en}, 32'd1);
    step();
    chk("R2 disable landed", {31'b0, xlat_en}, 32'd0);
    rd(32'h0, "R4 busy with outstanding");
    outst = 4'd0; ackp = 4'd2;
    step(); step();
    rd(32'h0, "R4 busy with pending acks");
    ackp = 4'd0;
    rd(32'h0, "R4 not idle before edge");
    rd(32'h8000_0000, "R4 idle after drain");

    // R6 illegal enable
    outst = 4'd1;
    step(); step();
    rd(32'h0, "R6 precondition busy");
    wr(32'h1);
    chk("R6 err set", {31'b0, err}, 32'd1);
    rd(32'h0, "R6 enable kept 0");
    step();
    chk("R6 xlat_en off", {31'b0, xlat_en}, 32'd0);
    outst = 4'd0;
    step(); step();
    wr(32'h2);
    wr(32'h0);
    chk("R11 err sticky", {31'b0, err}, 32'd1);
    do_reset();
    chk("R11 err cleared by reset", {31'b0, err}, 32'd0);

    // R9 reserved bits and layout
    wr(32'hFFFF_FFAE);
    rd(32'h8000_01A2, "R9 reserved ignored");
    chk("R9 no err", {31'b0, err}, 32'd0);
    // R10 other address
    wr_at(6'd1, 32'h0);
    rd(32'h8000_01A2, "R10 write elsewhere ignored");
    rd_at(6'd1, 32'h0, "R10 read elsewhere zero");

    // R8 interrupt gating
    unm = 1'b1; step();
    chk("R8 irq on", {31'b0, irq}, 32'd1);
    unm = 1'b0; step();
    chk("R8 irq off no status", {31'b0, irq}, 32'd0);
    wr(32'h0A2);
    unm = 1'b1; step();
    chk("R8 irq off no enable", {31'b0, irq}, 32'd0);
    rd(32'h8000_00A2, "R9 aux bit kept");
    wr(32'h1A2);
    chk("R8 irq re-enabled", {31'b0, irq}, 32'd1);
    unm = 1'b0;

    // R7 renumber while enabled
    wr(32'h1A3);
    step();
    wr(32'h153);
    chk("R7 err enabled", {31'b0, err}, 32'd1);
    rd(32'h0000_01A3, "R7 unit kept while enabled");

    // R7 renumber while busy and disabled, other fields applied
    do_reset();
    outst = 4'd2;
    step(); step();
    wr(32'h152);
    chk("R7 err busy", {31'b0, err}, 32'd1);
    rd(32'h0000_0102, "R7 unit kept, other fields applied");
    outst = 4'd0;
    step(); step();
    rd(32'h8000_0102, "R4 idle again");

    step();
    finish_run();
  end
endmodule